// File: doc/BRIEF.md
# SPI Slave Echo Responder

This block is an SPI slave working in mode 0: SCK idles low, data is sampled on the rising edge, and the most significant bit goes first. Every byte the master sends comes back to it one transfer later, because the slave's own shift register sits between the two. Until the first full transfer has finished after reset, the reply is zero.

The master can ask for a fixed message by sending the delete code 0x7F. The slave still returns 0x7F on the next transfer. After that it sends a fixed stream: the printable ASCII range, then carriage return, line feed, bell, and 0xFF as terminator. The master collects the stream by clocking dummy bytes until 0xFF arrives. While the stream is running, the bytes the master sends are not echoed.

SCK, MOSI and the active-low select come in without any relation to the system clock. They pass through synchronizers and are sampled with the system clock. Every captured byte is also presented locally, for example to a display, as a one-cycle strobe that carries the byte value.

Top module: `spi_echo_slave`

## Requirements
- R1: In echo mode, the byte received in transfer N is returned MSB first on MISO during transfer N+1, for any byte value.
- R2: After 0x7F is received in echo mode, the next transfer returns 0x7F. The following 99 transfers return 0x20, 0x21, … 0x7E in ascending order, then 0x0D, 0x0A, 0x07 and 0xFF.
- R3: After the transfer that returns 0xFF, the next transfer returns 0x00 and echo mode resumes. The byte received in that transfer is returned on the transfer after it.
- R4: The outgoing byte is loaded into the shift register only while select is high. While select is low, MISO changes only on falling SCK edges.
- R5: The bit on MOSI at each rising SCK edge is shifted in MSB first. The first reply bit is on MISO before the first rising edge.
- R6: After reset, MISO is 0, rx_valid is 0, and the first full transfer returns 0x00.
- R7: Bytes received while the message is being sent, including 0x7F, do not change the stream and are not echoed.
- R8: If select rises after fewer than 8 rising SCK edges, the partial byte is discarded, no strobe is given, and the next full transfer returns the reply that was pending before.
- R9: For each full byte, rx_valid is high for exactly one system clock cycle, with rx_data equal to the received byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCK must be no faster than clk/8 |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master, idle low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_ssn | input | 1 | Active-low slave select |
| spi_miso | output | 1 | Serial data to the master |
| rx_valid | output | 1 | One-cycle strobe for a captured byte. There is no ready signal: the consumer must accept every strobe |
| rx_data | output | 8 | Captured byte, valid while rx_valid is high |

## Verification
The bench builds the block with its default of two synchronizer stages. It drives SCK at one sixteenth of the system clock, which leaves several cycles of margin on each SCK phase after the synchronizer and edge-detect delays. It plays out a full delete-triggered stream of 101 transfers, sends 0x7F again inside the stream, and aborts a transfer after three bits. This reaches the stream boundaries, the restart of echo mode and the pending-reply retention.

// File: rtl/spi_echo_pkg.sv
package spi_echo_pkg;
  localparam int BYTE_W      = 8;
  localparam logic [7:0] DEL_CODE    = 8'h7F;
  localparam logic [7:0] SWEEP_FIRST = 8'h20;
  localparam logic [7:0] SWEEP_LAST  = 8'h7E;
  localparam int SWEEP_LEN  = int'(SWEEP_LAST) - int'(SWEEP_FIRST) + 1;
  localparam int TAIL_LEN   = 4;
  localparam int MSG_LEN    = SWEEP_LEN + TAIL_LEN;
  localparam int IDX_W      = $clog2(MSG_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MSG_LEN - 1);

  typedef enum logic [1:0] {SEQ_ECHO, SEQ_ARMED, SEQ_MSG} seq_mode_t;

  function automatic logic [7:0] msg_byte(input logic [IDX_W-1:0] idx);
    logic [7:0] r;
    if (int'(idx) < SWEEP_LEN) r = SWEEP_FIRST + 8'(idx);
    else begin
      case (int'(idx) - SWEEP_LEN)
        0:       r = 8'h0D;
        1:       r = 8'h0A;
        2:       r = 8'h07;
        default: r = 8'hFF;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/spi_echo_sync.sv
module spi_echo_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_echo_shifter.sv
module spi_echo_shifter
  import spi_echo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              mosi_s,
  input  logic              ssn_s,
  input  logic [BYTE_W-1:0] reply,
  output logic              miso,
  output logic              done,
  output logic [BYTE_W-1:0] byte_out
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              sck_prev;
  logic              sck_rise, sck_fall;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sh, tx_sh;

  assign sck_rise = sck_s & ~sck_prev & ~ssn_s;
  assign sck_fall = ~sck_s & sck_prev & ~ssn_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_prev <= 1'b0;
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      done     <= 1'b0;
      byte_out <= '0;
    end else begin
      sck_prev <= sck_s;
      done     <= 1'b0;
      if (ssn_s) begin
        bit_cnt <= '0;
        tx_sh   <= reply;
      end else begin
        if (sck_rise) begin
          rx_sh   <= {rx_sh[BYTE_W-2:0], mosi_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
            done     <= 1'b1;
            byte_out <= {rx_sh[BYTE_W-2:0], mosi_s};
          end
        end
        if (sck_fall) tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
      end
    end
  end

  assign miso = tx_sh[BYTE_W-1];

  AST_TX_HOLD_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ssn_s && !sck_fall) |=> $stable(tx_sh)); // R4
  AST_PARTIAL_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    ssn_s |=> (bit_cnt == '0) && !done); // R8
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
endmodule

// File: rtl/spi_echo_sequencer.sv
module spi_echo_sequencer
  import spi_echo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] reply
);
  seq_mode_t        mode;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode  <= SEQ_ECHO;
      idx   <= '0;
      reply <= '0;
    end else if (done) begin
      case (mode)
        SEQ_ECHO: begin
          reply <= rx_byte;
          if (rx_byte == DEL_CODE) mode <= SEQ_ARMED;
        end
        SEQ_ARMED: begin
          idx   <= '0;
          reply <= msg_byte('0);
          mode  <= SEQ_MSG;
        end
        default: begin
          if (idx == LAST_IDX) begin
            reply <= '0;
            mode  <= SEQ_ECHO;
          end else begin
            idx   <= idx + 1'b1;
            reply <= msg_byte(idx + 1'b1);
          end
        end
      endcase
    end
  end

  AST_ECHO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode == SEQ_ECHO) |=> reply == $past(rx_byte)); // R1
  AST_STREAM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode == SEQ_MSG && idx != LAST_IDX) |=> idx == $past(idx) + 1'b1); // R2
  AST_STREAM_END: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode == SEQ_MSG && idx == LAST_IDX) |=> (mode == SEQ_ECHO && reply == '0)); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(reply)); // R8
endmodule

// File: rtl/spi_echo_slave.sv
module spi_echo_slave
  import spi_echo_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_ssn,
  output logic              spi_miso,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data
);
  logic [2:0]        pins_s;
  logic [BYTE_W-1:0] reply;
  logic              done;
  logic [BYTE_W-1:0] rx_byte;

  spi_echo_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_ssn, spi_mosi, spi_sck}), .q(pins_s)
  );

  spi_echo_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .sck_s(pins_s[0]), .mosi_s(pins_s[1]), .ssn_s(pins_s[2]),
    .reply(reply), .miso(spi_miso), .done(done), .byte_out(rx_byte)
  );

  spi_echo_sequencer u_seq (
    .clk(clk), .rst_n(rst_n),
    .done(done), .rx_byte(rx_byte), .reply(reply)
  );

  assign rx_valid = done;
  assign rx_data  = rx_byte;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!rx_valid && !spi_miso)); // R6
endmodule

// File: tb/spi_echo_slave_tb.sv
module spi_echo_slave_tb;
  logic clk = 0, rst_n = 0;
  logic sck = 0, mosi = 0, ssn = 1;
  logic miso, rx_valid;
  logic [7:0] rx_data;
  int errors = 0, checks = 0;
  int strobes = 0;
  logic [7:0] last_rx = 0;
  bit finished = 0;

  // reference model state
  logic [7:0] exp_reply = 8'h00;
  logic [7:0] outq[$];
  bit end_pending = 0;

  localparam int HALF = 8;

  always #4 clk = ~clk;

  spi_echo_slave u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_mosi(mosi), .spi_ssn(ssn),
    .spi_miso(miso), .rx_valid(rx_valid), .rx_data(rx_data)
  );

  logic prev_valid = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin strobes++; last_rx = rx_data; end
      if (rx_valid && prev_valid) begin
        checks++; errors++;
        $display("FAIL R9 strobe longer than one cycle: actual=2+ expected=1");
      end
      prev_valid = rx_valid;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // reference model: advance after a full transfer that received b
  task automatic model_step(input logic [7:0] b);
    if (outq.size() > 0) begin
      exp_reply = outq.pop_front();
      if (exp_reply == 8'hFF && outq.size() == 0) end_pending = 1;
    end else if (end_pending) begin
      exp_reply = 8'h00;
      end_pending = 0;
    end else begin
      exp_reply = b;
      if (b == 8'h7F) begin
        for (int c = 8'h20; c <= 8'h7E; c++) outq.push_back(8'(c));
        outq.push_back(8'h0D); outq.push_back(8'h0A);
        outq.push_back(8'h07); outq.push_back(8'hFF);
      end
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] got, input string req);
    int s0;
    s0 = strobes;
    ssn = 0;
    wait_cyc(HALF);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      wait_cyc(HALF);
      got[i] = miso;
      sck = 1;
      wait_cyc(HALF);
      sck = 0;
    end
    wait_cyc(HALF);
    ssn = 1;
    wait_cyc(12);
    check({req, " returned byte"}, got, exp_reply);
    check("R9 one strobe per byte", strobes - s0, 1);
    check("R5 R9 strobe data MSB first", last_rx, tx);
    model_step(tx);
  endtask

  task automatic abort_xfer(input logic [7:0] tx, input int nbits);
    int s0;
    s0 = strobes;
    ssn = 0;
    wait_cyc(HALF);
    for (int i = 7; i > 7 - nbits; i--) begin
      mosi = tx[i];
      wait_cyc(HALF);
      sck = 1;
      wait_cyc(HALF);
      sck = 0;
    end
    wait_cyc(HALF);
    ssn = 1;
    wait_cyc(12);
    check("R8 no strobe on partial byte", strobes - s0, 0);
    check("R8 R4 pending reply on MISO while idle", miso, exp_reply[7]);
  endtask

  initial begin
    logic [7:0] g;
    wait_cyc(5);
    check("R6 MISO after reset", miso, 0);
    check("R6 rx_valid after reset", rx_valid, 0);
    rst_n = 1;
    wait_cyc(6);
    xfer(8'hA5, g, "R6 first reply zero");
    xfer(8'h3C, g, "R1 echo");
    xfer(8'h00, g, "R1 echo");
    xfer(8'hFF, g, "R1 echo");
    xfer(8'h80, g, "R1 echo");
    xfer(8'h01, g, "R1 echo");
    abort_xfer(8'hC3, 3);
    xfer(8'h5A, g, "R8 reply kept after abort");
    xfer(8'h7F, g, "R1 echo before DEL");
    xfer(8'h11, g, "R2 DEL echoed");
    for (int k = 0; k < 99; k++) begin
      if (k == 10) xfer(8'h7F, g, "R7 DEL ignored in stream");
      else xfer(8'(k), g, (k >= 95) ? "R2 R3 stream tail" : "R2 sweep");
    end
    xfer(8'h6B, g, "R3 zero after terminator");
    xfer(8'h2E, g, "R3 echo resumed");
    xfer(8'h00, g, "R1 echo after stream");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule